// File: doc/BRIEF.md
# Pulse Tester Register Bank

This block is the bus-side register file of a six-channel pulse tester. A host reaches it through a single-cycle Wishbone-style slave port. Through that port the host programs, for each channel, a delay, a pulse width and a repetition period. It also sets an enable mask. These values leave the block on flat parameter buses and feed the pulse generators outside it.

The block also watches each channel's input line and each channel's generated output line. It counts every rising edge on them, in a separate counter per line. The host reads the counters back, and it can freeze them at zero through a clear bit that stays set until software writes it back to zero. A constant identification word and a constant status byte let software confirm that it is talking to the right logic.

All pulse lines are treated as asynchronous. Each one passes through a synchroniser before edge detection, so a counter changes three clocks after its line rises.

Top module: `ptr_regbank`

## Requirements
- R1: A read of byte address 0x000 returns 0x54424C4F.
- R2: A read of byte address 0x004 returns 0x000000FF.
- R3: Each counter adds one for every rising edge on its line. The input counter of channel N (N = 1..6) reads at 0x100 + 8*(N-1), and the output counter of the same channel reads 4 bytes higher. Counter values are zero-extended to 32 bits.
- R4: A counter of CNT_W bits wraps silently from 2^CNT_W - 1 to 0. CNT_W is 32 by default.
- R5: Writing 1 to bit 0 of 0x130 clears every counter and keeps them at zero, ignoring edges, until a later write puts 0 in that bit. The bit reads back in bit 0, and all other bits of 0x130 read 0.
- R6: Address 0x200 holds the enable mask: bit k drives ch_en_o[k], which enables channel k+1. Bits 6 and up are not stored and read 0. ch_en_o changes only on a write to 0x200.
- R7: Channel N's delay register is at 0x204 + 4*(N-1), its width register at 0x21C + 4*(N-1) and its period register at 0x234 + 4*(N-1). Each is 32 bits, reads back what was written, and drives bits [32N-1 : 32(N-1)] of dly_o, wid_o or per_o respectively.
- R8: Reads of unmapped addresses return 0. Writes to read-only or unmapped addresses change nothing and are still acknowledged.
- R9: An access with wb_cyc_i and wb_stb_i both high is acknowledged with wb_ack_o high, together with its read data, exactly one clock later. There is no acknowledge without such a request.
- R10: After reset all writable registers, all counters, ch_en_o and wb_ack_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | AW | Byte address |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| pin_i | input | NCH | Channel input pulse lines (asynchronous) |
| pout_i | input | NCH | Channel output pulse lines (asynchronous) |
| ch_en_o | output | NCH | Channel enable mask |
| dly_o | output | NCH*PAR_W | Delay values, channel 1 in the low slice |
| wid_o | output | NCH*PAR_W | Pulse width values, channel 1 in the low slice |
| per_o | output | NCH*PAR_W | Period values, channel 1 in the low slice |

## Verification
The clear control and counting can land in the same clock. A counter may see a synchronised rising edge in exactly the cycle when the clear bit is set. The bench provokes this by pulsing every line while the clear bit is held high. It then judges the result at the ports: every counter must read zero. After the clear is released, a single new pulse must read back as exactly one.

The bench also drives a deliberate write to a counter address while that counter holds a known count. The count must survive the write unchanged.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam logic [31:0] ID_WORD   = 32'h5442_4C4F;
  localparam logic [31:0] STAT_WORD = 32'h0000_00FF;
  // Word indices (byte address / 4)
  localparam int W_ID   = 'h000;
  localparam int W_STAT = 'h001;
  localparam int W_CNT0 = 'h040;
  localparam int W_CLR  = 'h04C;
  localparam int W_EN   = 'h080;
  localparam int W_PAR0 = 'h081;
  localparam int NGRP   = 3;   // delay, width, period
endpackage

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [N-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[N-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[N-1];
endmodule

// File: rtl/ptr_edge_cnt.sv
module ptr_edge_cnt #(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             line_s, prev_q, rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  ptr_sync #(.N(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  assign rise   = line_s & ~prev_q;
  assign cnt_en = clr_i | rise;

  always_comb begin
    if (clr_i) cnt_d = '0;               // clear wins over a coincident edge
    else       cnt_d = cnt_q + 1'b1;     // silent wrap
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= line_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ptr_bus_ack.sv
module ptr_bus_ack #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] rd_i,
  output logic          ack_o,
  output logic [DW-1:0] dat_o
);
  logic          ack_q, ack_d;
  logic [DW-1:0] dat_q;

  assign ack_d = req_i & ~ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= ack_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dat_q <= '0;
    else if (ack_d) dat_q <= rd_i;
  end

  assign ack_o = ack_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/ptr_regbank.sv
module ptr_regbank
  import ptr_pkg::*;
#(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int NCH    = 6,
  parameter int CNT_W  = 32,
  parameter int PAR_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wb_cyc_i,
  input  logic               wb_stb_i,
  input  logic               wb_we_i,
  input  logic [AW-1:0]      wb_adr_i,
  input  logic [DW-1:0]      wb_dat_i,
  output logic [DW-1:0]      wb_dat_o,
  output logic               wb_ack_o,
  input  logic [NCH-1:0]     pin_i,
  input  logic [NCH-1:0]     pout_i,
  output logic [NCH-1:0]     ch_en_o,
  output logic [NCH*PAR_W-1:0] dly_o,
  output logic [NCH*PAR_W-1:0] wid_o,
  output logic [NCH*PAR_W-1:0] per_o
);
  localparam int WA   = AW - 2;
  localparam int NCNT = 2 * NCH;
  localparam logic [WA-1:0] A_ID   = WA'(W_ID);
  localparam logic [WA-1:0] A_STAT = WA'(W_STAT);
  localparam logic [WA-1:0] A_CLR  = WA'(W_CLR);
  localparam logic [WA-1:0] A_EN   = WA'(W_EN);

  logic [WA-1:0]    word;
  logic             req, wr_go;
  logic             unused_adr;
  logic             clr_q, clr_d, clr_we;
  logic [NCH-1:0]   en_q, en_d;
  logic             en_we;
  logic [PAR_W-1:0] par_q [NGRP][NCH];
  logic [PAR_W-1:0] par_d [NGRP][NCH];
  logic [CNT_W-1:0] cnt   [NCNT];
  logic             cnt_nz;
  logic [DW-1:0]    rd_d;

  assign word       = wb_adr_i[AW-1:2];
  assign unused_adr = ^wb_adr_i[1:0];
  assign req        = wb_cyc_i & wb_stb_i;
  assign wr_go      = req & wb_we_i & ~wb_ack_o;

  // Control register next state
  assign clr_we = wr_go & (word == A_CLR);
  assign en_we  = wr_go & (word == A_EN);
  assign clr_d  = wb_dat_i[0];
  assign en_d   = wb_dat_i[NCH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     clr_q <= 1'b0;
    else if (clr_we) clr_q <= clr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  // Parameter registers: next state
  always_comb begin
    for (int g = 0; g < NGRP; g++)
      for (int c = 0; c < NCH; c++) begin
        par_d[g][c] = par_q[g][c];
        if (wr_go && word == WA'(W_PAR0 + g*NCH + c))
          par_d[g][c] = wb_dat_i[PAR_W-1:0];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NGRP; g++)
        for (int c = 0; c < NCH; c++) par_q[g][c] <= '0;
    end else begin
      par_q <= par_d;
    end
  end

  // Edge counters: even slot = input line, odd slot = output line
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ptr_edge_cnt #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt_in (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(pin_i[c]),
      .clr_i (clr_q),
      .cnt_o (cnt[2*c])
    );
    ptr_edge_cnt #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt_out (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(pout_i[c]),
      .clr_i (clr_q),
      .cnt_o (cnt[2*c+1])
    );
    assign dly_o[c*PAR_W +: PAR_W] = par_q[0][c];
    assign wid_o[c*PAR_W +: PAR_W] = par_q[1][c];
    assign per_o[c*PAR_W +: PAR_W] = par_q[2][c];
  end

  always_comb begin
    cnt_nz = 1'b0;
    for (int i = 0; i < NCNT; i++) cnt_nz = cnt_nz | (|cnt[i]);
  end

  // Read mux
  always_comb begin
    rd_d = '0;
    if (word == A_ID)   rd_d = DW'(ID_WORD);
    if (word == A_STAT) rd_d = DW'(STAT_WORD);
    if (word == A_CLR)  rd_d = DW'(clr_q);
    if (word == A_EN)   rd_d = DW'(en_q);
    for (int i = 0; i < NCNT; i++)
      if (word == WA'(W_CNT0 + i)) rd_d = DW'(cnt[i]);
    for (int g = 0; g < NGRP; g++)
      for (int c = 0; c < NCH; c++)
        if (word == WA'(W_PAR0 + g*NCH + c)) rd_d = DW'(par_q[g][c]);
  end

  ptr_bus_ack #(.DW(DW)) u_ack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .rd_i  (rd_d),
    .ack_o (wb_ack_o),
    .dat_o (wb_dat_o)
  );

  assign ch_en_o = en_q;
endmodule

// File: rtl/ptr_regbank_chk.sv
module ptr_regbank_chk #(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int NCH = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cyc_i,
  input logic           stb_i,
  input logic           we_i,
  input logic [AW-1:0]  adr_i,
  input logic [DW-1:0]  dat_i,
  input logic           ack_i,
  input logic [NCH-1:0] ch_en_i,
  input logic           clr_i,
  input logic           cnt_nz_i
);
  // R9: a fresh request is acknowledged on the next clock
  p_ack_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && !ack_i) |=> ack_i);

  // R9: no acknowledge without a fresh request
  p_no_spurious_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i && stb_i && !ack_i) |=> !ack_i);

  // R1: identification word on read of word 0
  p_id_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && stb_i && !we_i && !ack_i && adr_i[AW-1:2] == '0)
      |=> dat_i == 32'h5442_4C4F);

  // R5: a held clear keeps every counter at zero
  p_clear_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !cnt_nz_i);

  // R6: the enable mask moves only on a write to its address
  p_en_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i && stb_i && we_i && !ack_i && adr_i[AW-1:2] == (AW-2)'('h80))
      |=> $stable(ch_en_i));
endmodule

bind ptr_regbank ptr_regbank_chk #(.AW(AW), .DW(DW), .NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cyc_i   (wb_cyc_i),
  .stb_i   (wb_stb_i),
  .we_i    (wb_we_i),
  .adr_i   (wb_adr_i),
  .dat_i   (wb_dat_o),
  .ack_i   (wb_ack_o),
  .ch_en_i (ch_en_o),
  .clr_i   (clr_q),
  .cnt_nz_i(cnt_nz)
);

// File: tb/ptr_regbank_tb.sv
module ptr_regbank_tb;
  localparam int NCH = 6;
  localparam int PW  = 32;
  localparam int CW  = 4;   // small counters so wrap is reachable

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [11:0]       adr = '0;
  logic [31:0]       wdat = '0;
  logic [31:0]       rdat;
  logic              ack;
  logic [NCH-1:0]    pin = '0, pout = '0;
  logic [NCH-1:0]    en;
  logic [NCH*PW-1:0] dly, wid, per;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  ptr_regbank #(.NCH(NCH), .CNT_W(CW), .PAR_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .pin_i(pin), .pout_i(pout), .ch_en_o(en),
    .dly_o(dly), .wid_o(wid), .per_o(per)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d;
    @(negedge clk);
    check("R9 write ack", 32'(ack), 32'd1);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
    @(negedge clk);
    check("R9 read ack", 32'(ack), 32'd1);
    d = rdat;
    cyc = 1'b0; stb = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int c, input bit outside, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (outside) pout[c] = 1'b1; else pin[c] = 1'b1;
      @(negedge clk);
      @(negedge clk); if (outside) pout[c] = 1'b0; else pin[c] = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] par_val(input int g, input int c);
    return 32'hA5000000 | 32'(g << 12) | 32'(c << 4) | 32'(g + c + 1);
  endfunction

  initial begin
    #(20000 * 10);
    n_err++;
    $display("FAIL R9 watchdog: act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    check("R10 ack", 32'(ack), 32'd0);
    check("R10 enable", 32'(en), 32'd0);
    check("R10 dly", dly[31:0], 32'd0);
    check("R10 per", per[NCH*PW-1 -: 32], 32'd0);
    for (int i = 0; i < 2*NCH; i++) rd_chk("R10 counter", 12'(12'h100 + 4*i), 32'd0);
    for (int i = 0; i < 3*NCH; i++) rd_chk("R10 param", 12'(12'h204 + 4*i), 32'd0);
    rd_chk("R10 clear", 12'h130, 32'd0);

    // R9: cycle without strobe gets no ack
    @(negedge clk); cyc = 1'b1;
    @(negedge clk); check("R9 no ack without stb", 32'(ack), 32'd0);
    @(negedge clk); check("R9 no ack without stb", 32'(ack), 32'd0);
    cyc = 1'b0;

    // R1, R2
    rd_chk("R1 id", 12'h000, 32'h5442_4C4F);
    rd_chk("R2 status", 12'h004, 32'h0000_00FF);

    // R8: unmapped reads, writes to read-only words
    rd_chk("R8 unmapped", 12'h008, 32'd0);
    rd_chk("R8 unmapped", 12'h134, 32'd0);
    rd_chk("R8 unmapped", 12'h24C, 32'd0);
    rd_chk("R8 unmapped", 12'hFFC, 32'd0);
    bus_wr(12'h000, 32'h0);
    rd_chk("R8 id after write", 12'h000, 32'h5442_4C4F);
    bus_wr(12'h004, 32'h0);
    rd_chk("R8 status after write", 12'h004, 32'h0000_00FF);
    bus_wr(12'h134, 32'hFFFF_FFFF);
    rd_chk("R8 unmapped after write", 12'h134, 32'd0);

    // R6: enable mask
    bus_wr(12'h200, 32'hFFFF_FFFF);
    check("R6 enable out", 32'(en), 32'h3F);
    rd_chk("R6 enable readback", 12'h200, 32'h3F);
    bus_wr(12'h200, 32'h15);
    check("R6 enable out", 32'(en), 32'h15);
    rd_chk("R6 enable readback", 12'h200, 32'h15);

    // R7: parameter registers, all channels and groups
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < NCH; c++) bus_wr(12'(12'h204 + 4*(g*NCH + c)), par_val(g, c));
    for (int g = 0; g < 3; g++)
      for (int c = 0; c < NCH; c++) begin
        rd_chk("R7 param readback", 12'(12'h204 + 4*(g*NCH + c)), par_val(g, c));
        if (g == 0) check("R7 delay bus", dly[c*PW +: PW], par_val(g, c));
        if (g == 1) check("R7 width bus", wid[c*PW +: PW], par_val(g, c));
        if (g == 2) check("R7 period bus", per[c*PW +: PW], par_val(g, c));
      end
    check("R6 enable unaffected", 32'(en), 32'h15);

    // R3: distinct counts per line
    for (int c = 0; c < NCH; c++) begin
      pulse(c, 1'b0, c + 1);
      pulse(c, 1'b1, 2*c + 1);
    end
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R3 input count", 12'(12'h100 + 8*c), 32'(c + 1));
      rd_chk("R3 output count", 12'(12'h104 + 8*c), 32'(2*c + 1));
    end

    // R4: wrap at 2^CW (1 + 17 = 18 -> 2)
    pulse(0, 1'b0, 17);
    rd_chk("R4 wrap", 12'h100, 32'd2);

    // R8: write to a counter address leaves it alone
    bus_wr(12'h100, 32'h7);
    rd_chk("R8 counter after write", 12'h100, 32'd2);

    // R5: clear held against incoming edges
    bus_wr(12'h130, 32'hFFFF_FFFF);
    rd_chk("R5 clear readback", 12'h130, 32'd1);
    @(negedge clk); pin = '1; pout = '1;
    repeat (3) @(negedge clk); pin = '0; pout = '0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2*NCH; i++) rd_chk("R5 held clear", 12'(12'h100 + 4*i), 32'd0);
    bus_wr(12'h130, 32'h0);
    rd_chk("R5 clear released", 12'h130, 32'd0);
    pulse(2, 1'b1, 1);
    rd_chk("R5 count after release", 12'h114, 32'd1);
    rd_chk("R5 other stays zero", 12'h110, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule